// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether a received frame is wanted because its 48-bit destination address lands on a set bit of a 64-entry hash table. The address folds down to a 6-bit index. Index bit n is the exclusive-or of every address bit whose position, taken modulo six, equals n. That index selects one table bit. Whether a set bit counts as a match depends on the address class and on one of two enable flags. A multicast address needs the multicast enable. A unicast address needs the unicast enable.

The table is loaded as two 32-bit words through a small write port. The two enable flags are loaded together through a second write strobe. A receive path presents the address with a one-cycle valid strobe. It gets back a registered verdict and the address class on the following cycle. Exact-address, broadcast and promiscuous acceptance are handled elsewhere.

Top module: `dst_hash_filter`

## Requirements
- R1: The table index bit n (n from 0 to 5) equals the XOR of address bits n, n+6, n+12, up to n+42, where `dst_addr[0]` is address bit 0.
- R2: `dst_addr[7:0]` carries the first received byte, and `dst_addr[0]` is its least significant bit. `res_mcast` is 1 for a valid result whose address bit 0 was 1, and 0 otherwise.
- R3: A write with `hash_sel` = 0 loads table bits 0 to 31 from `hash_wdata[31:0]`, with `hash_wdata[k]` going to table bit k. A write with `hash_sel` = 1 loads table bits 32 to 63, with `hash_wdata[k]` going to table bit 32+k.
- R4: For an address with bit 0 equal to 1, `res_hit` is 1 only when the multicast enable is set and the indexed table bit is set.
- R5: For an address with bit 0 equal to 0, `res_hit` is 1 only when the unicast enable is set and the indexed table bit is set.
- R6: With all 64 table bits set and the multicast enable on, every multicast address hits. Unicast addresses still follow R5.
- R7: `res_valid` is high exactly in the cycle after a cycle with `addr_valid` high. `res_hit` and `res_mcast` are 0 whenever `res_valid` is 0.
- R8: A table write or enable write in the same cycle as the strobe does not affect that lookup. The lookup uses the table and enables held before that clock edge, and the write applies to later lookups.
- R9: A synchronous active-high reset clears the table and both enables, and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Destination address strobe |
| dst_addr | input | 48 | Destination address, first received byte in bits 7:0 |
| hash_we | input | 1 | Table word write strobe |
| hash_sel | input | 1 | Table word select: 0 for bits 0-31, 1 for bits 32-63 |
| hash_wdata | input | 32 | Table word write data |
| cfg_we | input | 1 | Enable flags write strobe |
| cfg_ucast_en | input | 1 | Unicast hash enable value to load |
| cfg_mcast_en | input | 1 | Multicast hash enable value to load |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| res_hit | output | 1 | Address accepted by the hash table |
| res_mcast | output | 1 | Class of the looked-up address (1 = multicast) |

## Verification
The assertions assume that the write strobes and the address strobe are held low while reset is asserted. This matters because the word-placement check and the latency checks compare against the previous cycle's inputs. The stimulus drives every input on the falling edge and keeps all strobes low throughout reset. This keeps the previous-cycle values well defined. The assertions place no constraint on back-to-back strobes or on writes that collide with a strobe. The stimulus exercises both cases on purpose, and a cycle-accurate model in the bench checks them.

// File: rtl/hfilt_pkg.sv
package hfilt_pkg;

    localparam int ADDR_W_DEF = 48;
    localparam int IDX_W_DEF  = 6;
    localparam int WORD_W_DEF = 32;

    typedef enum logic {
        CLS_UNICAST   = 1'b0,
        CLS_MULTICAST = 1'b1
    } addr_class_e;

    typedef struct packed {
        logic ucast_en;
        logic mcast_en;
    } hash_cfg_t;

    typedef struct packed {
        logic        valid;
        logic        hit;
        addr_class_e cls;
    } lookup_res_t;

    function automatic addr_class_e class_of_lsb(input logic lsb);
        return lsb ? CLS_MULTICAST : CLS_UNICAST;
    endfunction

endpackage

// File: rtl/hfilt_fold.sv
module hfilt_fold #(
    parameter int ADDR_W = 48,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);

    // each index bit gathers every IDX_W-th address bit
    for (genvar n = 0; n < IDX_W; n++) begin : g_lane
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int k = n; k < ADDR_W; k += IDX_W) begin
                acc = acc ^ addr[k];
            end
        end
        assign idx[n] = acc;
    end

endmodule

// File: rtl/hfilt_table.sv
module hfilt_table
    import hfilt_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int WORD_W = 32,
    parameter int SEL_W  = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic                        cfg_we,
    input  hash_cfg_t                   cfg_in,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic                        rd_bit,
    output hash_cfg_t                   cfg_q,
    output logic [(1<<IDX_W)-1:0]       table_q
);

    localparam int TABLE_BITS = 1 << IDX_W;
    localparam int NUM_WORDS  = TABLE_BITS / WORD_W;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(w))) begin
                word_q <= wr_data;
            end
        end
        assign table_q[w*WORD_W +: WORD_W] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_in;
        end
    end

    assign rd_bit = table_q[rd_idx];

    // R3: the bottom word lands in the low table bits
    a_r3_low_word_placement: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en) && ($past(wr_sel) == '0))
            |-> (table_q[WORD_W-1:0] == $past(wr_data)));

    // R3: the top word lands in the high table bits
    a_r3_high_word_placement: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(wr_en) && ($past(wr_sel) == SEL_W'(NUM_WORDS-1)))
            |-> (table_q[TABLE_BITS-1 -: WORD_W] == $past(wr_data)));

endmodule

// File: rtl/hfilt_qualify.sv
module hfilt_qualify
    import hfilt_pkg::*;
(
    input  logic        addr_lsb,
    input  logic        table_bit,
    input  hash_cfg_t   cfg,
    output logic        hit,
    output addr_class_e cls
);

    always_comb begin
        cls = class_of_lsb(addr_lsb);
        unique case (cls)
            CLS_MULTICAST: hit = table_bit && cfg.mcast_en;
            default:       hit = table_bit && cfg.ucast_en;
        endcase
    end

endmodule

// File: rtl/dst_hash_filter.sv
module dst_hash_filter
    import hfilt_pkg::*;
#(
    parameter int ADDR_W = hfilt_pkg::ADDR_W_DEF,
    parameter int IDX_W  = hfilt_pkg::IDX_W_DEF,
    parameter int WORD_W = hfilt_pkg::WORD_W_DEF,
    parameter int SEL_W  = ((((1 << IDX_W) / WORD_W)) > 1) ? $clog2((1 << IDX_W) / WORD_W) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              hash_we,
    input  logic [SEL_W-1:0]  hash_sel,
    input  logic [WORD_W-1:0] hash_wdata,
    input  logic              cfg_we,
    input  logic              cfg_ucast_en,
    input  logic              cfg_mcast_en,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_mcast
);

    localparam int TABLE_BITS = 1 << IDX_W;

    logic [IDX_W-1:0]      idx;
    logic                  tbl_bit;
    hash_cfg_t             cfg_q;
    hash_cfg_t             cfg_in;
    logic [TABLE_BITS-1:0] table_q;
    logic                  qual_hit;
    addr_class_e           qual_cls;
    lookup_res_t           res_q;

    assign cfg_in = '{ucast_en: cfg_ucast_en, mcast_en: cfg_mcast_en};

    hfilt_fold #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fold (
        .addr (dst_addr),
        .idx  (idx)
    );

    hfilt_table #(.IDX_W(IDX_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (hash_we),
        .wr_sel  (hash_sel),
        .wr_data (hash_wdata),
        .cfg_we  (cfg_we),
        .cfg_in  (cfg_in),
        .rd_idx  (idx),
        .rd_bit  (tbl_bit),
        .cfg_q   (cfg_q),
        .table_q (table_q)
    );

    hfilt_qualify u_qual (
        .addr_lsb  (dst_addr[0]),
        .table_bit (tbl_bit),
        .cfg       (cfg_q),
        .hit       (qual_hit),
        .cls       (qual_cls)
    );

    // verdict is taken from pre-edge table and enables, then registered
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '{valid: 1'b0, hit: 1'b0, cls: CLS_UNICAST};
        end else begin
            res_q.valid <= addr_valid;
            res_q.hit   <= addr_valid && qual_hit;
            res_q.cls   <= addr_valid ? qual_cls : CLS_UNICAST;
        end
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_mcast = (res_q.cls == CLS_MULTICAST);

    // R7: a strobe produces a verdict on the next cycle
    a_r7_verdict_follows_strobe: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> res_valid);

    // R7: no verdict without a strobe one cycle earlier
    a_r7_no_spurious_verdict: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(addr_valid));

    // R7: hit and class stay low outside a valid verdict
    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_hit && !res_mcast));

    // R2: class comes from address bit 0 at the strobe
    a_r2_class_from_lsb: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_mcast == $past(dst_addr[0])));

    // R4: multicast hit needs the multicast enable held at the strobe
    a_r4_mcast_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (res_hit && res_mcast) |-> $past(cfg_q.mcast_en));

    // R5: unicast hit needs the unicast enable held at the strobe
    a_r5_ucast_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (res_hit && !res_mcast) |-> $past(cfg_q.ucast_en));

    // R6: full table with multicast enable accepts any multicast address
    a_r6_full_table_mcast: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_mcast && $past(&table_q) && $past(cfg_q.mcast_en)) |-> res_hit);

endmodule

// File: tb/dst_hash_filter_tb_top.sv
`timescale 1ns/1ps
module dst_hash_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic        hash_we = 1'b0;
    logic [0:0]  hash_sel = '0;
    logic [31:0] hash_wdata = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_ucast_en = 1'b0;
    logic        cfg_mcast_en = 1'b0;
    logic        res_valid, res_hit, res_mcast;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R9";
    bit armed = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dst_hash_filter dut_i (
        .clk(clk), .rst(rst), .addr_valid(addr_valid), .dst_addr(dst_addr),
        .hash_we(hash_we), .hash_sel(hash_sel), .hash_wdata(hash_wdata),
        .cfg_we(cfg_we), .cfg_ucast_en(cfg_ucast_en), .cfg_mcast_en(cfg_mcast_en),
        .res_valid(res_valid), .res_hit(res_hit), .res_mcast(res_mcast)
    );

    // behavioural reference: bit array plus two flags
    bit [63:0] m_tbl;
    bit        m_uc, m_mc;
    bit        e_valid, e_hit, e_mc;

    function automatic int ref_index(input logic [47:0] a);
        int r = 0;
        for (int k = 0; k < 48; k++) begin
            if (a[k]) r = r ^ (1 << (k % 6));
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_tbl = '0; m_uc = 0; m_mc = 0;
            e_valid = 0; e_hit = 0; e_mc = 0;
        end else begin
            e_valid = addr_valid;
            e_mc    = addr_valid && dst_addr[0];
            e_hit   = addr_valid && m_tbl[ref_index(dst_addr)] &&
                      (dst_addr[0] ? m_mc : m_uc);
            if (hash_we) m_tbl[int'(hash_sel)*32 +: 32] = hash_wdata;
            if (cfg_we) begin m_uc = cfg_ucast_en; m_mc = cfg_mcast_en; end
        end
        armed = 1'b1;
    end

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !done) begin
            check(cur_tag, "res_valid", res_valid, e_valid);
            check(cur_tag, "res_hit",   res_hit,   e_hit);
            check(cur_tag, "res_mcast", res_mcast, e_mc);
        end
    end

    task automatic wr_word(input int sel, input logic [31:0] d);
        @(negedge clk);
        hash_we = 1'b1; hash_sel = 1'(sel); hash_wdata = d;
        @(negedge clk);
        hash_we = 1'b0;
    endtask

    task automatic wr_cfg(input logic uc, input logic mc);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ucast_en = uc; cfg_mcast_en = mc;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [47:0] a);
        @(negedge clk);
        addr_valid = 1'b1; dst_addr = a;
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    task automatic set_bit_only(input int b);
        logic [63:0] v = 64'd1 << b;
        wr_word(0, v[31:0]);
        wr_word(1, v[63:32]);
    endtask

    // an address whose folded index is b, built from bits 6..11 only
    function automatic logic [47:0] addr_for(input int b, input logic mc, input logic [47:0] noise);
        logic [47:0] a = noise;
        a[0] = mc;
        a[11:6] = '0;
        a[11:6] = 6'(ref_index(a) ^ b);
        return a;
    endfunction

    logic [47:0] lfsr = 48'hA5C3_1E07_9B42;
    function automatic logic [47:0] step(input logic [47:0] s);
        return {s[46:0], s[47] ^ s[46] ^ s[20] ^ s[19]};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        cur_tag = "R9";
        check("R9", "res_valid in reset", res_valid, 1'b0);
        check("R9", "res_hit in reset", res_hit, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        wr_cfg(1, 1);
        lookup(48'h0000_0000_0001);
        lookup(48'h1234_5678_9AB0);

        cur_tag = "R3";
        wr_word(0, 32'h0000_0001);
        lookup(addr_for(0, 0, 48'h0));
        wr_word(1, 32'h8000_0000);
        lookup(addr_for(63, 0, 48'hFFFF_0000_0000));
        lookup(addr_for(32, 0, 48'h0));

        cur_tag = "R1";
        for (int b = 0; b < 64; b += 5) begin
            set_bit_only(b);
            lfsr = step(lfsr);
            lookup(addr_for(b, lfsr[3], lfsr));
            lookup(addr_for((b + 1) % 64, lfsr[3], lfsr));
            for (int s = 0; s < 3; s++) begin
                lfsr = step(lfsr);
                lookup(lfsr);
            end
        end

        cur_tag = "R4";
        set_bit_only(17);
        wr_cfg(0, 1);
        lookup(addr_for(17, 1, 48'h0));
        lookup(addr_for(17, 0, 48'h0));
        wr_cfg(1, 0);
        lookup(addr_for(17, 1, 48'h0));

        cur_tag = "R5";
        lookup(addr_for(17, 0, 48'h5555_AAAA_0000));
        wr_cfg(0, 0);
        lookup(addr_for(17, 0, 48'h5555_AAAA_0000));

        cur_tag = "R6";
        wr_word(0, 32'hFFFF_FFFF);
        wr_word(1, 32'hFFFF_FFFF);
        wr_cfg(0, 1);
        for (int i = 0; i < 40; i++) begin
            lfsr = step(lfsr);
            lookup(lfsr);
        end

        cur_tag = "R8";
        wr_word(0, 32'h0);
        wr_word(1, 32'h0);
        wr_cfg(1, 1);
        @(negedge clk);
        addr_valid = 1'b1; dst_addr = addr_for(5, 0, 48'h0);
        hash_we = 1'b1; hash_sel = 1'b0; hash_wdata = 32'h20;
        @(negedge clk);
        hash_we = 1'b0;
        check("R8", "write in strobe cycle ignored", res_hit, 1'b0);
        @(negedge clk);
        addr_valid = 1'b0;
        check("R8", "write applies to next lookup", res_hit, 1'b1);
        @(negedge clk);
        addr_valid = 1'b1; dst_addr = addr_for(5, 1, 48'h0);
        cfg_we = 1'b1; cfg_ucast_en = 1'b1; cfg_mcast_en = 1'b0;
        @(negedge clk);
        addr_valid = 1'b0; cfg_we = 1'b0;
        check("R8", "enable write in strobe cycle ignored", res_hit, 1'b1);

        cur_tag = "R7";
        @(negedge clk);
        addr_valid = 1'b1; dst_addr = addr_for(5, 0, 48'h0);
        repeat (3) @(negedge clk);
        addr_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R7", "idle after strobes", res_valid, 1'b0);

        cur_tag = "R9";
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        wr_cfg(1, 1);
        lookup(addr_for(5, 0, 48'h0));
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule